// File: doc/BRIEF.md
# Condition Flag Generator

This block produces the negative, zero, overflow and carry condition flags of an integer core, plus the extend flag used by multi-word arithmetic. The core hands it the class of the operation just finished, the result, the source operand and, for shifts, the bit shifted out. The block rebuilds the missing operand from the result and the source, works out the flags, and on a one-cycle `valid_i` strobe writes them, together with the extend flag and a set of upper control bits, into a registered status word.

Compares are judged on the low byte or the low half-word of the data path, with the sign at the top bit of that slice. Extended add and subtract can only clear the zero flag, never set it, so a zero test at the end of a chain covers every word of the chain. The extend flag follows the carry of ordinary and extended add and subtract and of shifts. A direct-load class writes the four flags from an input. Unassigned class codes change nothing and raise a one-cycle error.

Top module: `ccflag_gen`

## Requirements
- R1: After reset, `status_o` is all zeros and `err_o` is 0.
- R2: Class code 1 (logic): Z = 1 when the result is zero, N = result MSB, V = C = 0; X keeps its value.
- R3: Class code 2 (add, result = a + src): C = 1 when result < src unsigned; V = 1 when a and src share a sign and the result sign differs; X takes the new C.
- R4: Class code 3 (subtract, result = m - src): C = 1 when m < src unsigned; V = 1 when m and src differ in sign and the result sign differs from m; X takes the new C.
- R5: Class code 6 (add with extend, result = a + src + 1): C = 1 when result <= src unsigned; V as in R3; X takes C; new Z = old Z AND (result is zero).
- R6: Class code 7 (subtract with extend, result = m - src - 1): C = 1 when m <= src unsigned; V as in R4; X takes C; new Z = old Z AND (result is zero).
- R7: Class codes 4 and 5 (compare, subtract form) compute N, Z, V, C on the low BW or HW bits, the sign taken from the top bit of that slice; X keeps its value.
- R8: Class code 8 (shift): N and Z from the full result, V = 0, C and X both equal `carry_i`.
- R9: Class code 0 (direct load): the flags take `preset_i` as {N, Z, V, C}; X keeps its value.
- R10: Each accepted update writes `status_o` = {`hi_i`, X, N, Z, V, C}: C at bit 0, V at bit 1, Z at bit 2, N at bit 3, X at bit 4.
- R11: A strobe with class code 9 to 15 leaves `status_o` unchanged and drives `err_o` high for exactly the following cycle.
- R12: With `valid_i` low, `status_o` holds and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | One-cycle update strobe |
| op_i | input | 4 | Operation class code |
| result_i | input | DW | Operation result |
| src_i | input | DW | Source operand (addend or subtrahend) |
| carry_i | input | 1 | Bit shifted out, used by the shift class |
| preset_i | input | 4 | Flags for the direct-load class, {N, Z, V, C} |
| hi_i | input | SRW-5 | Upper control bits written with each update |
| status_o | output | SRW | Registered status word |
| err_o | output | 1 | One-cycle pulse for an unassigned class code |

## Verification
The bench builds the block with a 6-bit data path, 3-bit byte compares and 4-bit half-word compares. At that size every result and source pair can be driven for each arithmetic class, so all carry boundaries, the equal-operand edge of the extended classes, every signed overflow corner and the sign bit at each compare width are reached exhaustively. The extended classes are swept twice, once from a cleared and once from a set zero flag, to exercise both sides of the sticky rule.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;

  typedef enum logic [3:0] {
    CC_LOAD  = 4'd0,
    CC_LOGIC = 4'd1,
    CC_ADD   = 4'd2,
    CC_SUB   = 4'd3,
    CC_CMP_B = 4'd4,
    CC_CMP_H = 4'd5,
    CC_ADDX  = 4'd6,
    CC_SUBX  = 4'd7,
    CC_SHIFT = 4'd8
  } ccop_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccflags_t;

  localparam int FLAG_W = 4;
  localparam int X_POS  = 4;
  localparam int LOW_W  = FLAG_W + 1;
  localparam int N_SLICE = 3;

endpackage

// File: rtl/ccflag_arith.sv
// Flag equations for one slice width. The hidden operand is rebuilt from
// the result and the source: addend for add, minuend for subtract.
module ccflag_arith #(
  parameter int K = 32
) (
  input  logic [K-1:0] res_i,
  input  logic [K-1:0] src_i,
  input  logic         sub_i,
  input  logic         ext_i,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o,
  output logic         c_o
);

  logic [K-1:0] other;
  logic [K-1:0] ext_k;

  assign ext_k = {{(K-1){1'b0}}, ext_i};

  always_comb begin
    if (sub_i) other = res_i + src_i + ext_k;
    else       other = res_i - src_i - ext_k;
    n_o = res_i[K-1];
    z_o = (res_i == '0);
    if (sub_i) begin
      c_o = ext_i ? (other <= src_i) : (other < src_i);
      v_o = (other[K-1] ^ src_i[K-1]) & (other[K-1] ^ res_i[K-1]);
    end else begin
      c_o = ext_i ? (res_i <= src_i) : (res_i < src_i);
      v_o = ~(other[K-1] ^ src_i[K-1]) & (res_i[K-1] ^ src_i[K-1]);
    end
  end

endmodule

// File: rtl/ccflag_select.sv
// Chooses the flag set for the operation class and applies the sticky
// zero and extend rules.
module ccflag_select
  import ccflag_pkg::*;
(
  input  logic [3:0]         op_i,
  input  logic [N_SLICE-1:0] n_i,
  input  logic [N_SLICE-1:0] z_i,
  input  logic [N_SLICE-1:0] v_i,
  input  logic [N_SLICE-1:0] c_i,
  input  logic               carry_i,
  input  ccflags_t           preset_i,
  input  ccflags_t           old_f_i,
  input  logic               old_x_i,
  output ccflags_t           new_f_o,
  output logic               new_x_o,
  output logic               legal_o
);

  always_comb begin
    new_f_o = old_f_i;
    new_x_o = old_x_i;
    legal_o = 1'b1;
    case (ccop_e'(op_i))
      CC_LOAD:  new_f_o = preset_i;
      CC_LOGIC: new_f_o = '{n: n_i[0], z: z_i[0], v: 1'b0, c: 1'b0};
      CC_ADD, CC_SUB: begin
        new_f_o = '{n: n_i[0], z: z_i[0], v: v_i[0], c: c_i[0]};
        new_x_o = c_i[0];
      end
      CC_CMP_B: new_f_o = '{n: n_i[1], z: z_i[1], v: v_i[1], c: c_i[1]};
      CC_CMP_H: new_f_o = '{n: n_i[2], z: z_i[2], v: v_i[2], c: c_i[2]};
      CC_ADDX, CC_SUBX: begin
        new_f_o = '{n: n_i[0], z: z_i[0] & old_f_i.z, v: v_i[0], c: c_i[0]};
        new_x_o = c_i[0];
      end
      CC_SHIFT: begin
        new_f_o = '{n: n_i[0], z: z_i[0], v: 1'b0, c: carry_i};
        new_x_o = carry_i;
      end
      default:  legal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ccflag_gen.sv
module ccflag_gen
  import ccflag_pkg::*;
#(
  parameter int DW  = 32,
  parameter int BW  = 8,
  parameter int HW  = 16,
  parameter int SRW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [DW-1:0]    result_i,
  input  logic [DW-1:0]    src_i,
  input  logic             carry_i,
  input  logic [3:0]       preset_i,
  input  logic [SRW-6:0]   hi_i,
  output logic [SRW-1:0]   status_o,
  output logic             err_o
);

  localparam int HI_W = SRW - LOW_W;

  logic [N_SLICE-1:0] n_s, z_s, v_s, c_s;
  logic     is_sub, is_ext;
  ccflags_t new_f;
  logic     new_x, legal;

  assign is_sub = (op_i == CC_SUB) || (op_i == CC_SUBX) ||
                  (op_i == CC_CMP_B) || (op_i == CC_CMP_H);
  assign is_ext = (op_i == CC_ADDX) || (op_i == CC_SUBX);

  for (genvar g = 0; g < N_SLICE; g++) begin : g_slice
    localparam int KW = (g == 0) ? DW : ((g == 1) ? BW : HW);
    ccflag_arith #(.K(KW)) u_arith (
      .res_i (result_i[KW-1:0]),
      .src_i (src_i[KW-1:0]),
      .sub_i (is_sub),
      .ext_i (is_ext),
      .n_o   (n_s[g]),
      .z_o   (z_s[g]),
      .v_o   (v_s[g]),
      .c_o   (c_s[g])
    );
  end

  ccflag_select u_sel (
    .op_i     (op_i),
    .n_i      (n_s),
    .z_i      (z_s),
    .v_i      (v_s),
    .c_i      (c_s),
    .carry_i  (carry_i),
    .preset_i (ccflags_t'(preset_i)),
    .old_f_i  (ccflags_t'(status_o[FLAG_W-1:0])),
    .old_x_i  (status_o[X_POS]),
    .new_f_o  (new_f),
    .new_x_o  (new_x),
    .legal_o  (legal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      err_o    <= 1'b0;
    end else begin
      err_o <= valid_i & ~legal;
      if (valid_i && legal) status_o <= {hi_i, new_x, new_f};
    end
  end

  a_r11_illegal_hold: assert property (@(posedge clk) disable iff (rst)
    valid_i && op_i > 4'd8 |=> err_o && status_o == $past(status_o));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(status_o) && !err_o);

  a_r2_logic_vc_clear: assert property (@(posedge clk) disable iff (rst)
    valid_i && op_i == 4'd1 |=> status_o[1:0] == 2'b00);

  a_r5_sticky_zero: assert property (@(posedge clk) disable iff (rst)
    valid_i && (op_i == 4'd6 || op_i == 4'd7) && !status_o[2] |=> !status_o[2]);

  a_r8_shift_carry: assert property (@(posedge clk) disable iff (rst)
    valid_i && op_i == 4'd8 |=> status_o[0] == $past(carry_i) &&
                                 status_o[X_POS] == $past(carry_i));

  a_r10_upper_bits: assert property (@(posedge clk) disable iff (rst)
    valid_i && op_i <= 4'd8 |=> status_o[SRW-1:LOW_W] == $past(hi_i[HI_W-1:0]));

endmodule

// File: tb/ccflag_gen_test.sv
`timescale 1ns/1ps
module ccflag_gen_test;

  localparam int DW  = 6;
  localparam int BW  = 3;
  localparam int HW  = 4;
  localparam int SRW = 16;
  localparam int NV  = 1 << DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [DW-1:0] result_i = '0, src_i = '0;
  logic carry_i = 1'b0;
  logic [3:0] preset_i = '0;
  logic [SRW-6:0] hi_i = '0;
  logic [SRW-1:0] status_o;
  logic err_o;

  int total = 0;
  int bad = 0;
  logic [SRW-1:0] model = '0;

  always #5 clk = ~clk;

  ccflag_gen #(.DW(DW), .BW(BW), .HW(HW), .SRW(SRW)) uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
    .result_i(result_i), .src_i(src_i), .carry_i(carry_i),
    .preset_i(preset_i), .hi_i(hi_i), .status_o(status_o), .err_o(err_o)
  );

  // Returns {N,Z,V,C} of a K-bit add (sub=0) or subtract (sub=1) with extend.
  function automatic logic [3:0] ref_flags(int k, bit sub, int ext, int r, int s);
    int mask, half, o, so, ss, sr, big;
    bit n, z, v, c;
    mask = (1 << k) - 1; half = 1 << (k - 1);
    r = r & mask; s = s & mask;
    ss = (s >= half) ? s - (1 << k) : s;
    if (!sub) begin
      o = (r - s - ext) & mask;
      so = (o >= half) ? o - (1 << k) : o;
      c = (o + s + ext) > mask;
      big = so + ss + ext;
    end else begin
      o = (r + s + ext) & mask;
      so = (o >= half) ? o - (1 << k) : o;
      c = o < (s + ext);
      big = so - ss - ext;
    end
    sr = big;
    v = (sr > half - 1) || (sr < -half);
    n = r >= half; z = (r == 0);
    return {n, z, v, c};
  endfunction

  function automatic logic [SRW-1:0] ref_status(int op, int r, int s, bit cin,
      int pre, int hi, logic [SRW-1:0] old);
    logic [3:0] f;
    bit x;
    f = old[3:0]; x = old[4];
    case (op)
      0: f = pre[3:0];
      1: f = {r >= NV / 2, r == 0, 2'b00};
      2: begin f = ref_flags(DW, 0, 0, r, s); x = f[0]; end
      3: begin f = ref_flags(DW, 1, 0, r, s); x = f[0]; end
      4: f = ref_flags(BW, 1, 0, r, s);
      5: f = ref_flags(HW, 1, 0, r, s);
      6: begin f = ref_flags(DW, 0, 1, r, s); f[2] = f[2] & old[2]; x = f[0]; end
      7: begin f = ref_flags(DW, 1, 1, r, s); f[2] = f[2] & old[2]; x = f[0]; end
      8: begin f = {r >= NV / 2, r == 0, 1'b0, cin}; x = cin; end
      default: ;
    endcase
    return {hi[SRW-6:0], x, f};
  endfunction

  task automatic check(string req, logic [SRW:0] act, logic [SRW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual err/status=%h expected=%h", req, act, exp);
    end
  endtask

  // Strobe one update at a falling edge, sample at the next falling edge.
  task automatic step(string req, int op, int r, int s, bit cin, int pre, int hi);
    logic [SRW-1:0] e;
    bit il;
    il = op > 8;
    e = il ? model : ref_status(op, r, s, cin, pre, hi, model);
    valid_i = 1'b1; op_i = op[3:0]; result_i = r[DW-1:0]; src_i = s[DW-1:0];
    carry_i = cin; preset_i = pre[3:0]; hi_i = hi[SRW-6:0];
    @(negedge clk);
    valid_i = 1'b0;
    check(req, {err_o, status_o}, {il, e});
    model = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {err_o, status_o}, '0);

    // R9 direct load, every flag pattern, X preserved
    for (int p = 0; p < 16; p++) step("R9", 0, 0, 0, 0, p, p * 33);
    // R8 shift sets X, then R2 logic leaves X alone
    for (int r = 0; r < NV; r++) begin
      step("R8", 8, r, 0, r[0], 0, r);
      step("R2", 1, r, r ^ 5, 0, 0, r + 1);
    end
    // R3/R4/R7/R10 exhaustive pairs
    for (int r = 0; r < NV; r++)
      for (int s = 0; s < NV; s++) begin
        step("R3", 2, r, s, 0, 0, r * 7 + s);
        step("R4", 3, r, s, 0, 0, r * 3 + s);
        step("R7", 4, r, s, 0, 0, s);
        step("R7", 5, r, s, 1, 0, r);
      end
    // R5/R6 from both zero states
    for (int zs = 0; zs < 2; zs++)
      for (int r = 0; r < NV; r++)
        for (int s = 0; s < NV; s++) begin
          step("R10", 0, 0, 0, 0, zs * 4 + (s & 3), s);
          step("R5", 6, r, s, 0, 0, r ^ s);
          step("R10", 0, 0, 0, 0, zs * 4 + (r & 3), r);
          step("R6", 7, r, s, 0, 0, r + s);
        end
    // R11 unassigned codes: error for one cycle, state kept
    step("R9", 0, 0, 0, 0, 4'hA, 11'h5A5);
    for (int op = 9; op < 16; op++) begin
      step("R11", op, op, op + 1, 1, 4'h5, 11'h7FF);
      @(negedge clk);
      check("R11", {err_o, status_o}, {1'b0, model});
    end
    // R12 idle cycles with moving inputs
    for (int i = 0; i < 20; i++) begin
      op_i = i[3:0]; result_i = i[DW-1:0]; src_i = ~i[DW-1:0];
      carry_i = i[0]; preset_i = ~i[3:0]; hi_i = i[SRW-6:0];
      @(negedge clk);
      check("R12", {err_o, status_o}, {1'b0, model});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule